// File: doc/BRIEF.md
# Programmable priority interrupt controller

This block gathers up to eight peripheral interrupt lines and gives a processor a single interrupt request line. It keeps three eight-bit registers. The pending register holds levels that have seen a rising edge and are still asserted. The in-service register holds levels whose handlers are running. The mask register holds levels that are excluded from arbitration. A resolver compares the best eligible pending level with the best level in service and raises the interrupt only when the pending level ranks higher. When the processor acknowledges, the winning level moves from pending to in service, and a type byte is returned one cycle later. That byte is a programmed base with the level number in its low three bits.

Software controls the block through a small write port. Selector 0 writes the mask, selector 1 the base, selector 2 the mode and selector 3 an end-of-interrupt command. Priority starts in fixed order. It can also rotate, so that a level just finished drops to the bottom. A special mask mode lets masked in-service levels stop blocking lower levels. A polled mode keeps the interrupt line quiet and reports the best request on a status word, which software reads and acknowledges.

Top module: `ipc_ctrl`

## Requirements
- R1: After reset, int_out and ack_valid are low, poll_word is 0x00, the mask is clear, the base is 0, and the block is in fixed-priority, non-polled mode.
- R2: A request is recorded on a rising edge of its input, and only while the input stays high. A level that stays high after being serviced does not request again. If a request is withdrawn before acknowledge, int_out falls.
- R3: A level whose mask bit is 1 (selector 0, bit i = level i) never causes int_out. Clearing that bit while its input is still high lets the request through.
- R4: In fixed order, level 0 ranks highest and level 7 lowest. int_out is asserted only when the best unmasked pending level ranks strictly above every in-service level that blocks it.
- R5: An inta high at a clock edge yields ack_valid high for exactly the next cycle. When a request is pending and unblocked, ack_type = {base[7:3], level}, where the base is written through selector 1. That level enters service and its pending bit clears.
- R6: An acknowledge with no pending unblocked request returns {base[7:3], 3'd7} and changes no in-service bit.
- R7: Selector 3 carries the end-of-interrupt command. With bit 3 = 0 it clears the highest-ranked in-service bit. With bit 3 = 1 it clears the level in bits 2:0.
- R8: With mode bit 0 = 1 (rotate), the level cleared by an end-of-interrupt command becomes the lowest rank, so the next level up becomes the highest. Any mode write returns the order to level 7 lowest.
- R9: With mode bit 1 = 1 (special mask), an in-service level whose mask bit is set no longer blocks lower levels. Without this bit, masking an in-service level does not unblock anything.
- R10: With mode bit 2 = 1 (polled), int_out stays low. poll_word = {pending, 4'b0, level}, or 0x00 when nothing is eligible. poll_rd in this mode moves the reported level into service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Peripheral request lines, rising-edge sensitive |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge from the processor, one cycle |
| ack_valid | output | 1 | Type byte valid, the cycle after inta |
| ack_type | output | 8 | Type byte for the acknowledged level |
| poll_rd | input | 1 | Poll read strobe, acts as acknowledge in polled mode |
| poll_word | output | 8 | Pending flag and best level |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selector: 0 mask, 1 base, 2 mode, 3 end of interrupt |
| wr_data | input | 8 | Write data |

## Verification
A single-level sweep runs each level alone under two bases. It checks how the type byte is assembled, and that a held input does not re-trigger. Every ordered pair of levels is also tried, both when both lines rise together and when one line rises while the other is already in service. This separates the fixed ranking from the blocking comparison in both directions. A sweep of the rotation start point raises all other levels at once, which shows whether the order followed the cleared level. Short scenarios then contrast specific with non-specific end of interrupt, special mask with plain masking, and polled with interrupt-driven service.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_BASE = 2'd1,
    SEL_MODE = 2'd2,
    SEL_EOI  = 2'd3
  } ipc_sel_e;

  typedef struct packed {
    logic poll;
    logic smm;
    logic rot;
  } ipc_mode_t;

endpackage

// File: rtl/ipc_prio_pick.sv
// Finds the highest-ranked set bit of vec. The rank starts just above low_lvl.
module ipc_prio_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0]         vec,
  input  logic [$clog2(N)-1:0] low_lvl,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx,
  output logic [$clog2(N)-1:0] pos
);
  localparam int LW = $clog2(N);

  logic [N-1:0] rot;

  // rot[g] is the level that has rank g (rank 0 is the best).
  for (genvar g = 0; g < N; g++) begin : g_rot
    logic [LW-1:0] src;
    assign src    = low_lvl + LW'(g + 1);
    assign rot[g] = vec[src];
  end

  always_comb begin
    any = |vec;
    pos = '0;
    for (int j = N - 1; j >= 0; j--) begin
      if (rot[j]) pos = LW'(j);
    end
    idx = low_lvl + pos + LW'(1);
  end
endmodule

// File: rtl/ipc_cfg.sv
module ipc_cfg
  import ipc_pkg::*;
#(
  parameter int N  = 8,
  parameter int TW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [TW-1:0]        wr_data,
  input  logic                 rot_upd,
  input  logic [$clog2(N)-1:0] rot_lvl,
  output logic [N-1:0]         mask_q,
  output logic [TW-$clog2(N)-1:0] base_q,
  output ipc_mode_t            mode_q,
  output logic [$clog2(N)-1:0] low_lvl,
  output logic                 eoi_req,
  output logic                 eoi_spec,
  output logic [$clog2(N)-1:0] eoi_lvl
);
  localparam int LW = $clog2(N);

  logic [N-1:0]     mask_d;
  logic [TW-LW-1:0] base_d;
  ipc_mode_t        mode_d;
  logic [LW-1:0]    ptr_q, ptr_d;
  logic             mask_en, base_en, mode_en, ptr_en;

  assign mask_en  = wr_en && (wr_sel == SEL_MASK);
  assign base_en  = wr_en && (wr_sel == SEL_BASE);
  assign mode_en  = wr_en && (wr_sel == SEL_MODE);
  assign eoi_req  = wr_en && (wr_sel == SEL_EOI);
  assign eoi_spec = wr_data[LW];
  assign eoi_lvl  = wr_data[LW-1:0];
  assign ptr_en   = mode_en || rot_upd;

  always_comb begin
    mask_d = wr_data[N-1:0];
    base_d = wr_data[TW-1:LW];
    mode_d = ipc_mode_t'(wr_data[2:0]);
    ptr_d  = mode_en ? LW'(N - 1) : rot_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
      mode_q <= '0;
      ptr_q  <= LW'(N - 1);
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (base_en) base_q <= base_d;
      if (mode_en) mode_q <= mode_d;
      if (ptr_en)  ptr_q  <= ptr_d;
    end
  end

  assign low_lvl = mode_q.rot ? ptr_q : LW'(N - 1);
endmodule

// File: rtl/ipc_ctrl.sv
module ipc_ctrl
  import ipc_pkg::*;
#(
  parameter int N  = 8,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  output logic          int_out,
  input  logic          inta,
  output logic          ack_valid,
  output logic [TW-1:0] ack_type,
  input  logic          poll_rd,
  output logic [TW-1:0] poll_word,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [TW-1:0] wr_data
);
  localparam int LW = $clog2(N);
  localparam int PZ = TW - 1 - LW;

  logic [N-1:0]     irq_q, irr_q, irr_d, isr_q, isr_d;
  logic [N-1:0]     rise, req_vec, blk_vec, svc_vec, eoi_clr;
  logic [N-1:0]     mask_q;
  logic [TW-LW-1:0] base_q;
  ipc_mode_t        mode_q;
  logic             mode_poll;
  logic [LW-1:0]    low_lvl, eoi_lvl, eoi_sel;
  logic             eoi_req, eoi_spec, eoi_do, rot_upd;
  logic             req_any, blk_any, isr_any, hit, ack_evt, grant;
  logic [LW-1:0]    req_idx, req_pos, blk_idx, blk_pos, top_idx, top_pos, ack_lvl;
  logic             ack_valid_q, ack_valid_d;
  logic [TW-1:0]    ack_type_q, ack_type_d;

  ipc_cfg #(.N(N), .TW(TW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rot_upd(rot_upd), .rot_lvl(eoi_sel), .mask_q(mask_q), .base_q(base_q),
    .mode_q(mode_q), .low_lvl(low_lvl), .eoi_req(eoi_req), .eoi_spec(eoi_spec),
    .eoi_lvl(eoi_lvl)
  );

  assign mode_poll = mode_q.poll;
  assign rise      = irq_in & ~irq_q;
  assign req_vec   = irr_q & ~mask_q;
  assign blk_vec   = mode_q.smm ? (isr_q & ~mask_q) : isr_q;

  ipc_prio_pick #(.N(N)) u_req (
    .vec(req_vec), .low_lvl(low_lvl), .any(req_any), .idx(req_idx), .pos(req_pos));
  ipc_prio_pick #(.N(N)) u_blk (
    .vec(blk_vec), .low_lvl(low_lvl), .any(blk_any), .idx(blk_idx), .pos(blk_pos));
  ipc_prio_pick #(.N(N)) u_top (
    .vec(isr_q), .low_lvl(low_lvl), .any(isr_any), .idx(top_idx), .pos(top_pos));

  logic unused_pick;
  assign unused_pick = ^{blk_idx, top_pos};

  always_comb begin
    hit      = req_any && (!blk_any || (req_pos < blk_pos));
    ack_evt  = inta || (mode_q.poll && poll_rd);
    grant    = ack_evt && hit;
    svc_vec  = grant ? (N'(1) << req_idx) : '0;
    eoi_sel  = eoi_spec ? eoi_lvl : top_idx;
    eoi_do   = eoi_req && (eoi_spec || isr_any);
    eoi_clr  = eoi_do ? (N'(1) << eoi_sel) : '0;
    rot_upd  = eoi_do && mode_q.rot;
    irr_d    = irq_in & (irr_q | rise) & ~svc_vec;
    isr_d    = (isr_q & ~eoi_clr) | svc_vec;
    ack_lvl  = hit ? req_idx : LW'(N - 1);
    ack_valid_d = inta;
    ack_type_d  = inta ? {base_q, ack_lvl} : ack_type_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q       <= '0;
      irr_q       <= '0;
      isr_q       <= '0;
      ack_valid_q <= 1'b0;
      ack_type_q  <= '0;
    end else begin
      irq_q       <= irq_in;
      irr_q       <= irr_d;
      isr_q       <= isr_d;
      ack_valid_q <= ack_valid_d;
      if (inta) ack_type_q <= ack_type_d;
    end
  end

  assign int_out   = hit && !mode_q.poll;
  assign ack_valid = ack_valid_q;
  assign ack_type  = ack_type_q;
  assign poll_word = {hit, {PZ{1'b0}}, (hit ? req_idx : LW'(0))};
endmodule

module ipc_ctrl_chk #(
  parameter int N  = 8,
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  irq_in,
  input logic          int_out,
  input logic          inta,
  input logic          ack_valid,
  input logic [TW-1:0] ack_type,
  input logic [N-1:0]  irr_q,
  input logic [N-1:0]  isr_q,
  input logic [N-1:0]  mask_q,
  input logic          mode_poll
);
  localparam int LW = $clog2(N);

  // R10
  poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_poll |-> !int_out);
  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> ack_valid);
  // R5
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inta |=> !ack_valid);
  // R5
  ack_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_out) |=> isr_q[ack_type[LW-1:0]]);
  // R3
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr_q & ~mask_q) != '0));
  // R5
  one_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr_q & ~$past(isr_q)) <= 1);
  // R2
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irr_q & ~$past(irq_in)) == '0);
  // R6
  spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out && !mode_poll) |=> (ack_type[LW-1:0] == LW'(N - 1)));
endmodule

bind ipc_ctrl ipc_ctrl_chk #(.N(N), .TW(TW)) i_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_out(int_out), .inta(inta),
  .ack_valid(ack_valid), .ack_type(ack_type), .irr_q(irr_q), .isr_q(isr_q),
  .mask_q(mask_q), .mode_poll(mode_poll)
);

// File: tb/test_ipc_ctrl.sv
module test_ipc_ctrl;
  localparam int N  = 8;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          inta = 1'b0, poll_rd = 1'b0, wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [TW-1:0] wr_data = '0;
  logic          int_out, ack_valid;
  logic [TW-1:0] ack_type, poll_word;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] base = 8'h00;

  always #5 clk = ~clk;

  ipc_ctrl #(.N(N), .TW(TW)) i_ipc_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_out(int_out), .inta(inta),
    .ack_valid(ack_valid), .ack_type(ack_type), .poll_rd(poll_rd),
    .poll_word(poll_word), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ty(input int l);
    return {base[7:3], 3'(l)};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic raise(input int l);
    irq_in[l] = 1'b1;
    step();
  endtask

  task automatic do_ack(input string req, input logic [7:0] exp);
    inta = 1'b1;
    step();
    inta = 1'b0;
    chk(req, {7'd0, ack_valid}, 8'd1);
    chk(req, ack_type, exp);
  endtask

  task automatic clean();
    irq_in = '0;
    for (int l = 0; l < N; l++) wr(2'd3, 8'h08 | 8'(l));
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    step();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 int", {7'd0, int_out}, 8'd0);
    chk("R1 ackv", {7'd0, ack_valid}, 8'd0);
    chk("R1 poll", poll_word, 8'h00);

    // R5 R2 single levels under two bases
    for (int b = 0; b < 2; b++) begin
      base = (b == 0) ? 8'h40 : 8'hF8;
      for (int l = 0; l < N; l++) begin
        clean();
        wr(2'd1, base);
        raise(l);
        chk("R5 int", {7'd0, int_out}, 8'd1);
        do_ack("R5 type", ty(l));
        chk("R2 no rerequest", {7'd0, int_out}, 8'd0);
        step();
        chk("R5 ackv pulse", {7'd0, ack_valid}, 8'd0);
        wr(2'd3, 8'h00);
        chk("R2 held after eoi", {7'd0, int_out}, 8'd0);
      end
    end

    // R4 ordered pairs, simultaneous and nested
    for (int a = 0; a < N; a++) begin
      for (int c = 0; c < N; c++) begin
        if (a != c) begin
          clean();
          irq_in[a] = 1'b1; irq_in[c] = 1'b1;
          step();
          do_ack("R4 simultaneous", ty(a < c ? a : c));
          chk("R4 lower blocked", {7'd0, int_out}, 8'd0);
          wr(2'd3, 8'h00);
          chk("R4 after eoi", {7'd0, int_out}, 8'd1);
          clean();
          raise(a);
          do_ack("R4 first", ty(a));
          raise(c);
          chk("R4 nesting", {7'd0, int_out}, (c < a) ? 8'd1 : 8'd0);
        end
      end
    end

    // R2 withdrawal, R6 spurious
    clean();
    raise(4);
    chk("R2 raised", {7'd0, int_out}, 8'd1);
    irq_in[4] = 1'b0;
    step();
    chk("R2 withdrawn", {7'd0, int_out}, 8'd0);
    do_ack("R6 spurious", ty(7));
    raise(7);
    chk("R6 no service", {7'd0, int_out}, 8'd1);

    // R3 mask
    clean();
    wr(2'd0, 8'h08);
    raise(3);
    chk("R3 masked", {7'd0, int_out}, 8'd0);
    step();
    chk("R3 masked hold", {7'd0, int_out}, 8'd0);
    wr(2'd0, 8'h00);
    chk("R3 unmasked", {7'd0, int_out}, 8'd1);
    clean();
    wr(2'd0, 8'h01);
    irq_in[0] = 1'b1; irq_in[5] = 1'b1;
    step();
    do_ack("R3 mask skips", ty(5));

    // R7 non-specific vs specific
    clean();
    raise(5); do_ack("R7 setup", ty(5));
    raise(1); do_ack("R7 setup", ty(1));
    raise(3);
    chk("R7 blocked", {7'd0, int_out}, 8'd0);
    wr(2'd3, 8'h00);
    chk("R7 nonspecific", {7'd0, int_out}, 8'd1);
    clean();
    raise(5); do_ack("R7 setup", ty(5));
    raise(1); do_ack("R7 setup", ty(1));
    raise(3);
    wr(2'd3, 8'h0D);
    chk("R7 specific 5", {7'd0, int_out}, 8'd0);
    wr(2'd3, 8'h09);
    chk("R7 specific 1", {7'd0, int_out}, 8'd1);

    // R8 rotation sweep
    for (int k = 0; k < N; k++) begin
      clean();
      wr(2'd2, 8'h01);
      raise(k);
      do_ack("R8 setup", ty(k));
      wr(2'd3, 8'h00);
      irq_in[k] = 1'b0;
      step();
      irq_in = '1;
      step();
      do_ack("R8 rotated", ty((k + 1) % N));
      if (k == 3) begin
        wr(2'd3, 8'h0C);
        wr(2'd2, 8'h01);
        do_ack("R8 mode write restores", ty(0));
      end
    end

    // R9 special mask
    clean();
    raise(2); do_ack("R9 setup", ty(2));
    raise(5);
    chk("R9 blocked", {7'd0, int_out}, 8'd0);
    wr(2'd0, 8'h04);
    chk("R9 mask alone", {7'd0, int_out}, 8'd0);
    wr(2'd2, 8'h02);
    chk("R9 special", {7'd0, int_out}, 8'd1);
    do_ack("R9 lower served", ty(5));

    // R10 polled
    clean();
    wr(2'd2, 8'h04);
    irq_in[6] = 1'b1; irq_in[4] = 1'b1;
    step();
    chk("R10 quiet", {7'd0, int_out}, 8'd0);
    chk("R10 word", poll_word, 8'h84);
    poll_rd = 1'b1;
    step();
    poll_rd = 1'b0;
    chk("R10 served", poll_word, 8'h00);
    chk("R10 quiet", {7'd0, int_out}, 8'd0);
    wr(2'd3, 8'h00);
    chk("R10 next", poll_word, 8'h86);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule